// File: doc/BRIEF.md
# Time-Slot Bit Insertion Port

This block sits in the transmit path of a T1 or E1 framer and replaces chosen bit positions of the outgoing serial stream with bits fetched from an external serial source. It keeps its own position within the frame and a frame-parity flag, both aligned by a frame-sync input. Whenever the current position is one of the selected ones, it raises a strobe so that outside logic can present one NRZ bit. That bit takes the place of the payload bit on the line output.

A small register port sets the target time slot, the mask of bits within that slot, and the frame-parity restriction. The same port also enables insertion and selects whether the T1 framing bit is included. Every bit leaves the block exactly one line clock after it entered, whether it was replaced or not, so the block can be placed in a transmit pipeline without adjusting the alignment around it.

Top module: `slot_bit_splicer`

## Requirements
- R1: While reset is held, `line_o` and `xstb_o` are 0 and all three registers read back 0.
- R2: With `fsync_i` high, the bit on `line_i` is frame position 0. A T1 frame (`e1_mode_i`=0) holds 193 positions: position 0 is the framing bit and positions 1..192 are slots 0..23 of 8 bits each. An E1 frame holds 256 positions, which are slots 0..31 of 8 bits each.
- R3: `xstb_o` is high during the line clock cycles of the selected positions and low otherwise. It changes on the falling edge of `clk_i` in the cycle that carries the bit.
- R4: In the mask register (address 1), mask bit 7 selects the first transmitted bit of the slot and mask bit 0 selects the last. Any combination of mask bits may be set, and only the slot whose number equals control bits [4:0] is affected.
- R5: The frame that begins at `fsync_i` is even, and parity alternates with each following frame. Control bit 6 limits insertion to even frames and control bit 5 limits it to odd frames. With both bits clear, or both set, insertion applies to every frame.
- R6: At a selected position, `line_o` in the next cycle equals `xdata_i` sampled at the rising edge that ends the strobe cycle.
- R7: At every position that is not selected, `line_o` equals `line_i` delayed by one clock. This includes all positions while control bit 7 (enable) is clear, and no strobe is produced in that case.
- R8: Writing 0 to the control register (address 0) stops all insertion and all strobes, whatever the mask and framing-bit registers hold.
- R9: Bit 0 of register address 2 adds the T1 framing bit (position 0) as a selected position, subject to enable and parity. In E1 mode this bit has no effect.
- R10: Register address 0 is control, address 1 is mask and address 2 is framing-bit select, which reads back only bit 0. Address 3 reads 0 and ignores writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Line bit clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| e1_mode_i | input | 1 | 0 selects T1 framing, 1 selects E1 framing |
| fsync_i | input | 1 | Marks the first bit of a frame on `line_i` and restarts frame parity |
| line_i | input | 1 | Transmit serial payload in |
| xdata_i | input | 1 | External NRZ insertion data |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data for `reg_addr_i` |
| xstb_o | output | 1 | Insertion strobe, one pulse for each selected bit |
| line_o | output | 1 | Transmit serial stream out, one clock behind `line_i` |

## Verification
If the position counter slips, the strobe moves to the wrong line clock cycle. This shows on `xstb_o` at the first selected position after the fault, and therefore within one frame of 193 or 256 cycles. A wrong parity flag either suppresses the strobes of a whole frame or adds strobes to a frame that should have none, so it is visible within two frames. A fault in the output selection shows on `line_o` one clock after the affected bit, because the external data is always driven as the inverse of the payload bit it replaces.

// File: rtl/sbs_pkg.sv
package sbs_pkg;
  localparam int unsigned T1_LEN  = 193;
  localparam int unsigned E1_LEN  = 256;
  localparam int unsigned POS_W   = $clog2(E1_LEN);
  localparam int unsigned BIT_W   = 3;
  localparam int unsigned SLOT_W  = POS_W - BIT_W;
  localparam int unsigned MASK_W  = 1 << BIT_W;
  localparam int unsigned REG_W   = 8;
  localparam int unsigned ADDR_W  = 2;

  localparam logic [ADDR_W-1:0] A_CTL  = 2'd0;
  localparam logic [ADDR_W-1:0] A_MASK = 2'd1;
  localparam logic [ADDR_W-1:0] A_FBIT = 2'd2;

  typedef struct packed {
    logic              en;
    logic              even_only;
    logic              odd_only;
    logic [SLOT_W-1:0] slot;
  } slot_ctl_t;
endpackage

// File: rtl/sbs_frame_tracker.sv
module sbs_frame_tracker
  import sbs_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             e1_mode_i,
  input  logic             fsync_i,
  output logic [POS_W-1:0] pos_o,
  output logic             odd_o
);
  logic [POS_W-1:0] pos_q;
  logic             odd_q;
  logic [POS_W-1:0] last_pos;
  logic             at_last;

  assign pos_o    = fsync_i ? '0 : pos_q;
  assign odd_o    = fsync_i ? 1'b0 : odd_q;
  assign last_pos = e1_mode_i ? POS_W'(E1_LEN - 1) : POS_W'(T1_LEN - 1);
  // >= also recovers from a mode switch mid-frame
  assign at_last  = pos_o >= last_pos;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pos_q <= '0;
      odd_q <= 1'b0;
    end else begin
      pos_q <= at_last ? '0 : pos_o + 1'b1;
      odd_q <= at_last ? ~odd_o : odd_o;
    end
  end
endmodule

// File: rtl/sbs_cfg_regs.sv
module sbs_cfg_regs
  import sbs_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [REG_W-1:0]  wdata_i,
  output logic [REG_W-1:0]  rdata_o,
  output slot_ctl_t         ctl_o,
  output logic [MASK_W-1:0] mask_o,
  output logic              fbit_o
);
  slot_ctl_t         ctl_q;
  logic [MASK_W-1:0] mask_q;
  logic              fbit_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_q  <= '0;
      mask_q <= '0;
      fbit_q <= 1'b0;
    end else if (we_i) begin
      unique case (addr_i)
        A_CTL:   ctl_q  <= slot_ctl_t'(wdata_i);
        A_MASK:  mask_q <= wdata_i[MASK_W-1:0];
        A_FBIT:  fbit_q <= wdata_i[0];
        default: ;
      endcase
    end
  end

  always_comb begin
    unique case (addr_i)
      A_CTL:   rdata_o = REG_W'(ctl_q);
      A_MASK:  rdata_o = REG_W'(mask_q);
      A_FBIT:  rdata_o = REG_W'(fbit_q);
      default: rdata_o = '0;
    endcase
  end

  assign ctl_o  = ctl_q;
  assign mask_o = mask_q;
  assign fbit_o = fbit_q;
endmodule

// File: rtl/sbs_bit_select.sv
module sbs_bit_select
  import sbs_pkg::*;
(
  input  logic              e1_mode_i,
  input  logic [POS_W-1:0]  pos_i,
  input  logic              odd_i,
  input  slot_ctl_t         ctl_i,
  input  logic [MASK_W-1:0] mask_i,
  input  logic              fbit_i,
  output logic              hit_o
);
  logic              is_fbit;
  logic [POS_W-1:0]  off;
  logic [SLOT_W-1:0] slot;
  logic [BIT_W-1:0]  bidx;
  logic              par_ok;
  logic              slot_hit;

  assign is_fbit  = !e1_mode_i && (pos_i == '0);
  // T1 payload starts one position after the framing bit
  assign off      = e1_mode_i ? pos_i : pos_i - 1'b1;
  assign slot     = off[POS_W-1:BIT_W];
  assign bidx     = off[BIT_W-1:0];
  // first transmitted bit maps to the mask MSB
  assign slot_hit = (slot == ctl_i.slot) && mask_i[~bidx];
  assign par_ok   = (ctl_i.even_only == ctl_i.odd_only) ||
                    (ctl_i.even_only && !odd_i) ||
                    (ctl_i.odd_only && odd_i);
  assign hit_o    = ctl_i.en && par_ok && (is_fbit ? fbit_i : slot_hit);
endmodule

// File: rtl/sbs_splice_out.sv
module sbs_splice_out (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hit_i,
  input  logic line_i,
  input  logic xdata_i,
  output logic xstb_o,
  output logic line_o
);
  logic stb_q;
  logic line_q;

  // strobe launched mid-bit, external data captured at the closing edge
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stb_q <= 1'b0;
    else         stb_q <= hit_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) line_q <= 1'b0;
    else         line_q <= stb_q ? xdata_i : line_i;
  end

  assign xstb_o = stb_q;
  assign line_o = line_q;
endmodule

// File: rtl/slot_bit_splicer.sv
module slot_bit_splicer
  import sbs_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              e1_mode_i,
  input  logic              fsync_i,
  input  logic              line_i,
  input  logic              xdata_i,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [REG_W-1:0]  reg_wdata_i,
  output logic [REG_W-1:0]  reg_rdata_o,
  output logic              xstb_o,
  output logic              line_o
);
  logic [POS_W-1:0]  pos;
  logic              odd;
  slot_ctl_t         ctl;
  logic [MASK_W-1:0] mask;
  logic              fbit;
  logic              hit;

  sbs_frame_tracker u_trk (
    .clk_i, .rst_ni, .e1_mode_i, .fsync_i,
    .pos_o (pos),
    .odd_o (odd)
  );

  sbs_cfg_regs u_regs (
    .clk_i, .rst_ni,
    .we_i    (reg_we_i),
    .addr_i  (reg_addr_i),
    .wdata_i (reg_wdata_i),
    .rdata_o (reg_rdata_o),
    .ctl_o   (ctl),
    .mask_o  (mask),
    .fbit_o  (fbit)
  );

  sbs_bit_select u_sel (
    .e1_mode_i,
    .pos_i  (pos),
    .odd_i  (odd),
    .ctl_i  (ctl),
    .mask_i (mask),
    .fbit_i (fbit),
    .hit_o  (hit)
  );

  sbs_splice_out u_out (
    .clk_i, .rst_ni,
    .hit_i   (hit),
    .line_i,
    .xdata_i,
    .xstb_o,
    .line_o
  );
endmodule

module slot_bit_splicer_chk
  import sbs_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              e1_mode_i,
  input logic              line_i,
  input logic              xdata_i,
  input logic              xstb_o,
  input logic              line_o,
  input logic [POS_W-1:0]  pos,
  input slot_ctl_t         ctl,
  input logic              fbit
);
  logic [POS_W-1:0]  off_c;
  logic [SLOT_W-1:0] slot_c;
  logic              fpos_c;

  assign fpos_c = !e1_mode_i && (pos == '0);
  assign off_c  = e1_mode_i ? pos : pos - 1'b1;
  assign slot_c = off_c[POS_W-1:BIT_W];

  // R7
  no_strobe_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctl.en |-> !xstb_o);
  // R7
  pass_through_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !xstb_o |=> (line_o == $past(line_i)));
  // R6
  splice_data_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xstb_o |=> (line_o == $past(xdata_i)));
  // R4
  strobe_slot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xstb_o && !fpos_c) |-> (slot_c == ctl.slot));
  // R9
  fbit_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xstb_o && fpos_c) |-> fbit);
  // R2
  t1_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!e1_mode_i && pos == POS_W'(T1_LEN - 1)) |=> (pos == '0));
endmodule

bind slot_bit_splicer slot_bit_splicer_chk u_chk (
  .clk_i, .rst_ni, .e1_mode_i, .line_i, .xdata_i, .xstb_o, .line_o,
  .pos, .ctl, .fbit
);

// File: tb/slot_bit_splicer_test.sv
`timescale 1ns/1ps
module slot_bit_splicer_test;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       e1_mode_i = 1'b0;
  logic       fsync_i = 1'b0;
  logic       line_i = 1'b0;
  logic       xdata_i = 1'b0;
  logic       reg_we_i = 1'b0;
  logic [1:0] reg_addr_i = 2'd0;
  logic [7:0] reg_wdata_i = 8'd0;
  logic [7:0] reg_rdata_o;
  logic       xstb_o;
  logic       line_o;

  int n_chk = 0;
  int n_fail = 0;

  // bench model state
  int       m_pos = 0;
  bit       m_fodd = 0;
  bit       m_e1 = 0;
  bit       m_en = 0, m_ev = 0, m_od = 0, m_fbit = 0;
  int       m_slot = 0;
  bit [7:0] m_mask = 0;
  bit [15:0] lfsr = 16'hACE1;

  slot_bit_splicer uut (.*);

  always #2 clk_i = ~clk_i;

  task automatic chk(string tag, logic act, logic exp, string what);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s act=%b exp=%b pos=%0d", tag, what, act, exp, m_pos);
    end
  endtask

  task automatic chk8(string tag, logic [7:0] act, logic [7:0] exp, string what);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
    end
  endtask

  function automatic bit exp_hit();
    int  off;
    bit  par;
    par = (m_ev == m_od) ? 1'b1 : (m_ev ? !m_fodd : m_fodd);
    if (!m_en || !par) return 1'b0;
    if (!m_e1 && m_pos == 0) return m_fbit;
    off = m_e1 ? m_pos : m_pos - 1;
    return ((off / 8) == m_slot) && m_mask[7 - (off % 8)];
  endfunction

  // one line bit; entered and left at posedge+1
  task automatic step(bit fs, string tag);
    bit din, hit;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    din = lfsr[0];
    if (fs) begin m_pos = 0; m_fodd = 0; end
    hit = exp_hit();
    fsync_i = fs;
    line_i  = din;
    @(negedge clk_i); #1;
    chk(tag, xstb_o, hit, "strobe");
    xdata_i = ~din;
    @(posedge clk_i); #1;
    chk(tag, line_o, hit ? ~din : din, "line out");
    m_pos++;
    if (m_pos == (m_e1 ? 256 : 193)) begin m_pos = 0; m_fodd = !m_fodd; end
  endtask

  task automatic run(int n, bit e1, string tag);
    m_e1 = e1;
    e1_mode_i = e1;
    for (int i = 0; i < n; i++) step(i == 0, tag);
    fsync_i = 1'b0;
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    reg_we_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(posedge clk_i); #1;
    reg_we_i = 1'b0;
  endtask

  task automatic setcfg(bit en, bit ev, bit od, int slot, bit [7:0] mask, bit fb);
    wr(2'd0, {en, ev, od, 5'(slot)});
    wr(2'd1, mask);
    wr(2'd2, {7'd0, fb});
    m_en = en; m_ev = ev; m_od = od; m_slot = slot; m_mask = mask; m_fbit = fb;
  endtask

  task automatic t_reset();
    #5;
    chk("R1", line_o, 1'b0, "line_o in reset");
    chk("R1", xstb_o, 1'b0, "xstb_o in reset");
    for (int a = 0; a < 3; a++) begin
      reg_addr_i = 2'(a); #1;
      chk8("R1", reg_rdata_o, 8'h00, "reg in reset");
    end
    @(posedge clk_i); #1;
    rst_ni = 1'b1;
    @(posedge clk_i); #1;
  endtask

  task automatic t_regs();
    wr(2'd0, 8'hA5); reg_addr_i = 2'd0; #1;
    chk8("R10", reg_rdata_o, 8'hA5, "ctl readback");
    wr(2'd1, 8'h3C); reg_addr_i = 2'd1; #1;
    chk8("R10", reg_rdata_o, 8'h3C, "mask readback");
    wr(2'd2, 8'hFF); reg_addr_i = 2'd2; #1;
    chk8("R10", reg_rdata_o, 8'h01, "fbit readback");
    wr(2'd3, 8'hFF); reg_addr_i = 2'd3; #1;
    chk8("R10", reg_rdata_o, 8'h00, "unmapped read");
    reg_addr_i = 2'd0; #1;
    chk8("R10", reg_rdata_o, 8'hA5, "ctl after unmapped write");
    reg_addr_i = 2'd1; #1;
    chk8("R10", reg_rdata_o, 8'h3C, "mask after unmapped write");
    setcfg(0, 0, 0, 0, 8'h00, 0);
  endtask

  task automatic t_passthru();
    setcfg(0, 0, 0, 3, 8'hFF, 1);
    run(2 * 193, 0, "R7");
  endtask

  task automatic t_t1_mask();
    setcfg(1, 0, 0, 8, 8'b1100_0011, 0);
    run(2 * 193 + 5, 0, "R2 R3 R4 R6");
    setcfg(1, 0, 0, 23, 8'b0101_1010, 0);
    run(193 + 3, 0, "R2 R4");
  endtask

  task automatic t_parity();
    setcfg(1, 1, 0, 2, 8'h10, 0);
    run(4 * 193, 0, "R5 even");
    setcfg(1, 0, 1, 2, 8'h10, 0);
    run(4 * 193, 0, "R5 odd");
    setcfg(1, 1, 1, 2, 8'h11, 0);
    run(3 * 193, 0, "R5 both");
  endtask

  task automatic t_fbit();
    setcfg(1, 0, 1, 0, 8'h00, 1);
    run(4 * 193, 0, "R9 t1");
    setcfg(1, 0, 0, 5, 8'h00, 1);
    run(2 * 256, 1, "R9 e1");
    setcfg(1, 0, 0, 31, 8'h81, 0);
    run(2 * 256 + 2, 1, "R2 R4 e1");
    setcfg(1, 0, 0, 0, 8'h80, 0);
    run(256 + 2, 1, "R2 e1 slot0");
  endtask

  task automatic t_zero_ctl();
    setcfg(1, 0, 0, 4, 8'hFF, 1);
    run(193, 0, "R8 before");
    wr(2'd0, 8'h00);
    m_en = 0; m_ev = 0; m_od = 0; m_slot = 0;
    reg_addr_i = 2'd0; #1;
    chk8("R8", reg_rdata_o, 8'h00, "ctl cleared");
    run(2 * 193, 0, "R8 after");
  endtask

  initial begin
    #800000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_regs();
    t_passthru();
    t_t1_mask();
    t_parity();
    t_fbit();
    t_zero_ctl();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule